// File: doc/BRIEF.md
# Branch Target and Link Unit

This block resolves control-flow instructions in the execute stage of a 32-bit core that runs in one of two instruction-set modes: a full-width mode with 4-byte instructions and a compressed mode with 2-byte instructions. Each cycle with `in_valid` high it takes one branch operation together with:

- the current PC,
- a sign-extended immediate,
- a register operand,
- the condition-pass result.

One cycle later it presents the registered results with `out_valid`:

- the next PC,
- a taken flag,
- a link-register write value and its write enable.

The execution mode lives inside the block as a two-state machine. `MODE_FULL` is the reset state; `MODE_COMP` is the compressed mode. The state is always visible on `res_mode` and is the mode used to evaluate the incoming operation. Three transitions are named:

- **hold** keeps the state.
- **toggle** flips it. It is taken by an immediate mode-switching call.
- **load** copies bit 0 of the register operand into it, with 1 meaning `MODE_COMP`. It is taken by the register-form exchanges.

Any operation that is not taken uses hold, and so does any cycle with `in_valid` low.

Operation codes on `op_code` are:

| Code | Operation |
|---|---|
| 0 | plain branch |
| 1 | branch with link |
| 2 | immediate mode-switching call |
| 3 | register exchange with link |
| 4 | register exchange |
| 5 | compare-and-branch on zero |
| 6 | compare-and-branch on nonzero |
| 7 | no branch |

Top module: `brt_unit`

## Requirements
- R1: After synchronous active-high reset, `out_valid` and `link_we` are 0 and `res_mode` is 0 (full-width). A cycle with `in_valid` high yields `out_valid` high on the next cycle. A cycle with `in_valid` low yields `out_valid` and `link_we` low on the next cycle.
- R2: For codes 0 and 1, when `cond_ok` is 1, `res_pc` is `pc + imm` modulo 2^32 and `res_taken` is 1.
- R3: For codes 1 and 2 when taken, `link_we` is 1. `link_val` is `pc | 1` in compressed mode and `pc - 4` in full-width mode.
- R4: For code 3 when taken, `link_we` is 1. `link_val` is `(pc - 2) | 1` in compressed mode and `pc - 4` in full-width mode.
- R5: For code 2 when taken, `res_pc` is `(pc & ~3) + imm` in compressed mode and `pc + imm` in full-width mode. `res_mode` is inverted.
- R6: For codes 3 and 4 when taken, `res_mode` becomes `rs_val[0]`. `res_pc` is `rs_val` with bit 0 cleared, and bit 1 is also cleared when `rs_val[0]` is 0.
- R7: Codes 0 and 4 never raise `link_we`.
- R8: Code 5 is taken exactly when `rs_val` is 0, and code 6 exactly when `rs_val` is nonzero, whatever `cond_ok` is. When taken, `res_pc` is `pc + imm`. Neither code raises `link_we` or changes `res_mode`.
- R9: A non-taken operation, including code 7 and codes 0 to 4 with `cond_ok` 0, gives `res_taken` 0 and `link_we` 0. `res_mode` is unchanged, and `res_pc` is `pc + 2` in compressed mode or `pc + 4` in full-width mode.
- R10: While `in_valid` is low, `res_mode` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Branch operation code |
| pc | input | 32 | Address of the branch instruction as seen by execute |
| imm | input | 32 | Sign-extended branch offset |
| rs_val | input | 32 | Register operand (target or compare value) |
| cond_ok | input | 1 | Condition predicate passed |
| out_valid | output | 1 | Registered results valid |
| res_pc | output | 32 | Next PC |
| res_taken | output | 1 | Branch taken |
| link_we | output | 1 | Link register write enable |
| link_val | output | 32 | Link register write value |
| res_mode | output | 1 | Current execution mode, 1 = compressed |

## Verification
The assertions assume that every input is a known 0 or 1 whenever `in_valid` is high. They also assume reset is applied before the first operation, so the mode state starts in `MODE_FULL`.

The stimulus drives only two-state values from a fixed-seed `$urandom` stream, on the falling edge. It deliberately forces a zero register operand in a share of the random vectors so that both compare-and-branch outcomes occur. Idle gaps are interleaved so that the hold transition is exercised in both modes.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [2:0] {
        OP_B    = 3'd0,
        OP_BL   = 3'd1,
        OP_BLXI = 3'd2,
        OP_BLXR = 3'd3,
        OP_BXR  = 3'd4,
        OP_CBZ  = 3'd5,
        OP_CBNZ = 3'd6,
        OP_NONE = 3'd7
    } br_op_e;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_COMP = 1'b1
    } isa_mode_e;

    typedef enum logic [1:0] {
        MX_HOLD   = 2'd0,
        MX_TOGGLE = 2'd1,
        MX_LOAD   = 2'd2
    } mode_act_e;

endpackage

// File: rtl/brt_decide.sv
module brt_decide
    import brt_pkg::*;
(
    input  br_op_e    op,
    input  logic      cond_ok,
    input  logic      rs_zero,
    output logic      taken,
    output logic      interwork,
    output mode_act_e act
);

    always_comb begin
        taken     = 1'b0;
        interwork = 1'b0;
        unique case (op)
            OP_B, OP_BL, OP_BLXI: taken = cond_ok;
            OP_BLXR, OP_BXR: begin
                taken     = cond_ok;
                interwork = 1'b1;
            end
            OP_CBZ:  taken = rs_zero;
            OP_CBNZ: taken = !rs_zero;
            OP_NONE: taken = 1'b0;
            default: taken = 1'b0;
        endcase
    end

    always_comb begin
        act = MX_HOLD;
        if (taken) begin
            if (op == OP_BLXI) begin
                act = MX_TOGGLE;
            end else if (interwork) begin
                act = MX_LOAD;
            end
        end
    end

endmodule

// File: rtl/brt_target.sv
module brt_target
    import brt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_op_e            op,
    input  isa_mode_e         mode,
    input  logic              taken,
    input  logic              interwork,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   imm,
    input  logic [XLEN-1:0]   rs_val,
    output logic [XLEN-1:0]   nxt_pc
);

    localparam logic [XLEN-1:0] STEP_FULL = XLEN'(4);
    localparam logic [XLEN-1:0] STEP_COMP = XLEN'(2);
    localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] xfer_pc;
    logic [XLEN-1:0] iw_pc;

    always_comb begin
        seq_pc = pc + ((mode == MODE_COMP) ? STEP_COMP : STEP_FULL);
        rel_pc = pc + imm;
        if (mode == MODE_COMP) begin
            xfer_pc = (pc & WORD_MASK) + imm;
        end else begin
            xfer_pc = rel_pc;
        end
        iw_pc    = rs_val;
        iw_pc[0] = 1'b0;
        if (!rs_val[0]) begin
            iw_pc[1] = 1'b0;
        end
    end

    always_comb begin
        if (!taken) begin
            nxt_pc = seq_pc;
        end else if (interwork) begin
            nxt_pc = iw_pc;
        end else if (op == OP_BLXI) begin
            nxt_pc = xfer_pc;
        end else begin
            nxt_pc = rel_pc;
        end
    end

endmodule

// File: rtl/brt_link.sv
module brt_link
    import brt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_op_e          op,
    input  isa_mode_e       mode,
    input  logic            taken,
    input  logic [XLEN-1:0] pc,
    output logic            we,
    output logic [XLEN-1:0] val
);

    localparam logic [XLEN-1:0] BACK_FULL = XLEN'(4);
    localparam logic [XLEN-1:0] BACK_COMP = XLEN'(2);
    localparam logic [XLEN-1:0] LSB_SET   = XLEN'(1);

    always_comb begin
        we  = 1'b0;
        val = '0;
        if (taken) begin
            unique case (op)
                OP_BL, OP_BLXI: begin
                    we  = 1'b1;
                    val = (mode == MODE_COMP) ? (pc | LSB_SET) : (pc - BACK_FULL);
                end
                OP_BLXR: begin
                    we  = 1'b1;
                    val = (mode == MODE_COMP) ? ((pc - BACK_COMP) | LSB_SET)
                                              : (pc - BACK_FULL);
                end
                default: begin
                    we  = 1'b0;
                    val = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/brt_mode_fsm.sv
module brt_mode_fsm
    import brt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    input  mode_act_e act,
    input  logic      load_bit,
    output isa_mode_e mode
);

    isa_mode_e state;
    isa_mode_e state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MODE_FULL;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (step) begin
            unique case (state)
                MODE_FULL: begin
                    if (act == MX_TOGGLE) begin
                        state_nxt = MODE_COMP;
                    end else if (act == MX_LOAD && load_bit) begin
                        state_nxt = MODE_COMP;
                    end
                end
                MODE_COMP: begin
                    if (act == MX_TOGGLE) begin
                        state_nxt = MODE_FULL;
                    end else if (act == MX_LOAD && !load_bit) begin
                        state_nxt = MODE_FULL;
                    end
                end
                default: state_nxt = MODE_FULL;
            endcase
        end
    end

    assign mode = state;

    // R10: no step, no change of mode
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state));

    // R5: toggle transition always changes the state
    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (step && act == MX_TOGGLE) |=> state != $past(state));

endmodule

// File: rtl/brt_unit.sv
module brt_unit
    import brt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [2:0]      op_code,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] rs_val,
    input  logic            cond_ok,
    output logic            out_valid,
    output logic [XLEN-1:0] res_pc,
    output logic            res_taken,
    output logic            link_we,
    output logic [XLEN-1:0] link_val,
    output logic            res_mode
);

    br_op_e          op;
    isa_mode_e       mode;
    logic            taken;
    logic            interwork;
    mode_act_e       act;
    logic [XLEN-1:0] nxt_pc;
    logic            lnk_we;
    logic [XLEN-1:0] lnk_val;
    logic            rs_zero;

    assign op      = br_op_e'(op_code);
    assign rs_zero = (rs_val == '0);

    brt_decide u_decide (
        .op        (op),
        .cond_ok   (cond_ok),
        .rs_zero   (rs_zero),
        .taken     (taken),
        .interwork (interwork),
        .act       (act)
    );

    brt_target #(.XLEN(XLEN)) u_target (
        .op        (op),
        .mode      (mode),
        .taken     (taken),
        .interwork (interwork),
        .pc        (pc),
        .imm       (imm),
        .rs_val    (rs_val),
        .nxt_pc    (nxt_pc)
    );

    brt_link #(.XLEN(XLEN)) u_link (
        .op    (op),
        .mode  (mode),
        .taken (taken),
        .pc    (pc),
        .we    (lnk_we),
        .val   (lnk_val)
    );

    brt_mode_fsm u_mode (
        .clk      (clk),
        .rst      (rst),
        .step     (in_valid),
        .act      (act),
        .load_bit (rs_val[0]),
        .mode     (mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_pc    <= '0;
            res_taken <= 1'b0;
            link_we   <= 1'b0;
            link_val  <= '0;
        end else begin
            out_valid <= in_valid;
            link_we   <= in_valid & lnk_we;
            if (in_valid) begin
                res_pc    <= nxt_pc;
                res_taken <= taken;
                link_val  <= lnk_val;
            end
        end
    end

    assign res_mode = mode;

    // R1: a presented operation produces a strobe one cycle later
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1: idle cycles give no strobe and no link write
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !link_we));

    // R6: interworking write sets mode from operand bit 0 and clears target bit 0
    a_r6_interwork_mode: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_ok && (op_code == 3'd3 || op_code == 3'd4))
        |=> (res_pc[0] == 1'b0 && res_mode == $past(rs_val[0])));

    // R8: compare-and-branch never links and never touches the mode
    a_r8_cb_no_side: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_code == 3'd5 || op_code == 3'd6))
        |=> (!link_we && $stable(res_mode)));

    // R7: plain branch and register exchange never link
    a_r7_no_link: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_code == 3'd0 || op_code == 3'd4)) |=> !link_we);

    // R9: failed predicate leaves the mode alone and writes no link
    a_r9_fail_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cond_ok && op_code <= 3'd4)
        |=> (!link_we && !res_taken && $stable(res_mode)));

endmodule

// File: tb/brt_unit_test.sv
`timescale 1ns/1ps
module brt_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_code;
    logic [31:0] pc, imm, rs_val;
    logic        cond_ok;
    logic        out_valid;
    logic [31:0] res_pc;
    logic        res_taken;
    logic        link_we;
    logic [31:0] link_val;
    logic        res_mode;

    int n_chk = 0;
    int n_bad = 0;
    logic model_mode;

    always #2 clk = ~clk;

    brt_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .pc(pc), .imm(imm), .rs_val(rs_val), .cond_ok(cond_ok),
        .out_valid(out_valid), .res_pc(res_pc), .res_taken(res_taken),
        .link_we(link_we), .link_val(link_val), .res_mode(res_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] iw_target(input logic [31:0] r);
        logic [31:0] t;
        t = {r[31:1], 1'b0};
        if (!r[0]) t[1] = 1'b0;
        return t;
    endfunction

    function automatic void model(
        input  logic [2:0]  op, input logic [31:0] p, input logic [31:0] im,
        input  logic [31:0] r,  input logic m, input logic c,
        output logic [31:0] npc, output logic tk, output logic we,
        output logic [31:0] lv, output logic nm);
        tk  = (op == 3'd5) ? (r == 0) : (op == 3'd6) ? (r != 0) :
              (op == 3'd7) ? 1'b0 : c;
        nm  = m;
        we  = 1'b0;
        lv  = 32'd0;
        npc = p + (m ? 32'd2 : 32'd4);
        if (tk) begin
            case (op)
                3'd0: npc = p + im;
                3'd1: begin npc = p + im; we = 1'b1; lv = m ? (p | 32'd1) : (p - 32'd4); end
                3'd2: begin
                    npc = m ? ((p & ~32'd3) + im) : (p + im);
                    we = 1'b1; lv = m ? (p | 32'd1) : (p - 32'd4); nm = !m;
                end
                3'd3: begin
                    npc = iw_target(r); we = 1'b1;
                    lv = m ? ((p - 32'd2) | 32'd1) : (p - 32'd4); nm = r[0];
                end
                3'd4: begin npc = iw_target(r); nm = r[0]; end
                default: npc = p + im;
            endcase
        end
    endfunction

    function automatic string pc_tag(input logic [2:0] op, input logic tk);
        if (!tk) return "R9";
        case (op)
            3'd0, 3'd1: return "R2";
            3'd2: return "R5";
            3'd3, 3'd4: return "R6";
            default: return "R8";
        endcase
    endfunction

    function automatic string lk_tag(input logic [2:0] op, input logic tk);
        if (!tk) return "R9";
        case (op)
            3'd1, 3'd2: return "R3";
            3'd3: return "R4";
            3'd0, 3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(input logic [2:0] op, input logic [31:0] p,
                         input logic [31:0] im, input logic [31:0] r, input logic c);
        logic [31:0] e_pc, e_lv;
        logic e_tk, e_we, e_m;
        model(op, p, im, r, model_mode, c, e_pc, e_tk, e_we, e_lv, e_m);
        in_valid = 1'b1; op_code = op; pc = p; imm = im; rs_val = r; cond_ok = c;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
        chk(pc_tag(op, e_tk), res_pc, e_pc);
        chk(pc_tag(op, e_tk), {31'd0, res_taken}, {31'd0, e_tk});
        chk(lk_tag(op, e_tk), {31'd0, link_we}, {31'd0, e_we});
        if (e_we) chk(lk_tag(op, e_tk), link_val, e_lv);
        chk((op == 3'd2) ? "R5" : (op == 3'd3 || op == 3'd4) ? "R6" : "R9",
            {31'd0, res_mode}, {31'd0, e_m});
        model_mode = e_m;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            op_code = 3'($urandom_range(0, 7));
            rs_val = $urandom();
            cond_ok = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk("R1 idle valid", {31'd0, out_valid, link_we}, 32'd0);
            chk("R10 mode hold", {31'd0, res_mode}, {31'd0, model_mode});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; in_valid = 1'b0; op_code = 3'd0; pc = 0; imm = 0; rs_val = 0; cond_ok = 0;
        model_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset link", {31'd0, link_we}, 32'd0);
        chk("R1 reset mode", {31'd0, res_mode}, 32'd0);
        rst = 1'b0;

        // directed corner cases
        apply(3'd1, 32'h0000_1000, 32'h0000_0040, 32'h0, 1'b1);       // R2 R3 full BL
        apply(3'd0, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0, 1'b1);       // R2 wrap
        apply(3'd1, 32'h0000_2000, 32'h0000_0010, 32'h0, 1'b0);       // R9 failed predicate
        apply(3'd2, 32'h0000_1008, 32'hFFFF_FFF8, 32'h0, 1'b1);       // R5 to compressed
        apply(3'd2, 32'h0000_1006, 32'h0000_0100, 32'h0, 1'b1);       // R5 R3 from compressed
        apply(3'd4, 32'h0000_3000, 32'h0, 32'h0000_2003, 1'b1);       // R6 into compressed
        apply(3'd3, 32'h0000_4006, 32'h0, 32'h0000_5006, 1'b1);       // R4 R6 into full
        apply(3'd5, 32'h0000_6000, 32'h0000_0008, 32'h0, 1'b0);       // R8 cbz taken despite cond
        apply(3'd6, 32'h0000_6000, 32'h0000_0008, 32'h0, 1'b1);       // R8 cbnz not taken
        apply(3'd6, 32'h0000_6000, 32'h0000_0008, 32'h1, 1'b0);       // R8 cbnz taken
        apply(3'd7, 32'h0000_7000, 32'h0000_0008, 32'h1, 1'b1);       // R9 no-branch code
        apply(3'd4, 32'h0000_7000, 32'h0, 32'h0000_8001, 1'b1);       // R7 R6 no link
        idle(3);                                                       // R10 in compressed
        apply(3'd3, 32'h0000_9002, 32'h0, 32'h0000_A002, 1'b0);       // R9 compressed sequential

        for (int k = 0; k < 600; k++) begin
            logic [31:0] r;
            r = $urandom();
            if ($urandom_range(0, 3) == 0) r = 32'd0;
            apply(3'($urandom_range(0, 7)), {$urandom()} & ~32'd1, $urandom(), r,
                  1'($urandom_range(0, 1)));
            if ($urandom_range(0, 7) == 0) idle(1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule